// File: doc/BRIEF.md
# PWM Cycle Timebase Counter

This block is the 16-bit timebase behind one PWM channel. A start bit gates it. While that bit is set, the count advances on a tick from a two-stage prescaler. The first stage divides the system clock by a programmable integer. The second stage divides the result further by a power of two, picked by a small clock-select field. Downstream duty comparators read the count, the count direction, and two strobes that mark the turning points of the waveform.

There are two counting shapes, selected by a mode input. In sawtooth mode the count rises, and on the tick where it equals the cycle value it restarts from zero. In triangle mode the count climbs to the cycle value, turns, falls back to zero and turns again. A one-cycle peak strobe marks the top turn and a one-cycle valley strobe marks the bottom turn. A word write loads the count directly at any time and takes priority over a tick. The count comes out of reset at 0x0001, not zero.

Top module: `pwm_timebase`

## Requirements
- R1: After a synchronous reset the count reads 0x0001, dir_down reads 0 (counting up), and peak and valley are both low.
- R2: While run is low and no write is issued, the count holds and no tick is produced.
- R3: A cycle with wr_en high loads wr_data into the count, visible on the next cycle; any tick in that cycle is discarded.
- R4: With run held high, a tick occurs once every (psc+1) * 2^cksel clock cycles (cksel = 0..3). The first tick falls on the last cycle of the first such period after run rises.
- R5: In sawtooth mode (comp_mode = 0), a tick increments the count, except that a tick taken while the count equals cycle loads zero. That restart tick pulses peak, provided cycle is nonzero.
- R6: In sawtooth mode with cycle = 0, a count of zero stays at zero on every tick.
- R7: In triangle mode (comp_mode = 1), counting up, a tick raises the count by one. On the tick where the count reaches cycle, dir_down becomes 1 and peak pulses. If the count is already at or above cycle while counting up, the tick only turns the direction and pulses peak.
- R8: In triangle mode, counting down, a tick lowers the count by one. On the tick where the count reaches zero, dir_down becomes 0 and valley pulses. A tick taken at zero while counting down only turns the direction and pulses valley.
- R9: peak and valley are never high together, and neither stays high for two cycles in a row.
- R10: One cycle after any cycle with comp_mode = 0, dir_down reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start bit; counting and prescaler run only while high |
| psc | input | 8 | Integer prescale value; divides by psc+1 |
| cksel | input | 2 | Power-of-two post-divider select, divide by 2^cksel |
| comp_mode | input | 1 | 0 = sawtooth restart, 1 = triangle up/down |
| cycle | input | 16 | Cycle (turning) value |
| wr_en | input | 1 | Word write strobe for the count |
| wr_data | input | 16 | Count value to load |
| count | output | 16 | Current count |
| dir_down | output | 1 | 1 while counting down (triangle mode only) |
| peak | output | 1 | One-cycle strobe at the top turn or sawtooth restart |
| valley | output | 1 | One-cycle strobe at the bottom turn |

## Verification
The bench aims at the turning points. A design that flips direction one tick late overshoots the cycle value by one, or falls below zero into 0xFFFF. A design that strobes on the wrong tick puts peak out of line with the count. It also checks the tick period at odd prescale values with every post-divider setting; an off-by-one in either divider stage shifts every following count. Cycle values of zero and one are covered, where a sawtooth restart or a triangle turn happens on every tick and careless logic would stick or emit back-to-back strobes. Writes issued while running, and counts loaded above the cycle value, show whether a write is lost to a tick and whether the direction logic recovers from an out-of-range start.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_RST = cnt_t'(1);

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        cnt_t value;
        dir_e dir;
        logic peak;
        logic valley;
    } tbase_t;

    function automatic tbase_t tbase_reset();
        tbase_t s;
        s.value  = CNT_RST;
        s.dir    = DIR_UP;
        s.peak   = 1'b0;
        s.valley = 1'b0;
        return s;
    endfunction

    function automatic cnt_t inc(cnt_t v);
        return cnt_t'(v + 1'b1);
    endfunction

    function automatic cnt_t dec(cnt_t v);
        return cnt_t'(v - 1'b1);
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PSC_W   = 8,
    parameter int CKSEL_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [PSC_W-1:0]   psc,
    input  logic [CKSEL_W-1:0] cksel,
    output logic               tick
);
    localparam int DIV_W = (1 << CKSEL_W) - 1;

    logic [PSC_W-1:0] pcnt;
    logic [DIV_W-1:0] dcnt;
    logic [DIV_W-1:0] mask;
    logic             base;

    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(cksel));
        end
    end

    assign base = (pcnt == psc);
    assign tick = run && base && ((dcnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
            dcnt <= '0;
        end else begin
            pcnt <= base ? '0 : pcnt + 1'b1;
            if (base) begin
                dcnt <= dcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_cnt_core.sv
module pwm_cnt_core
    import pwm_timebase_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   comp_mode,
    input  cnt_t   cycle,
    input  logic   wr_en,
    input  cnt_t   wr_data,
    output tbase_t state
);
    tbase_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        st_d.peak   = 1'b0;
        st_d.valley = 1'b0;
        if (!comp_mode) begin
            st_d.dir = DIR_UP;
        end
        if (wr_en) begin
            st_d.value = wr_data;
        end else if (tick) begin
            if (!comp_mode) begin
                if (st_q.value == cycle) begin
                    st_d.value = '0;
                    st_d.peak  = (cycle != '0);
                end else begin
                    st_d.value = inc(st_q.value);
                end
            end else if (st_q.dir == DIR_UP) begin
                if (st_q.value >= cycle) begin
                    st_d.dir  = DIR_DOWN;
                    st_d.peak = 1'b1;
                end else begin
                    st_d.value = inc(st_q.value);
                    if (inc(st_q.value) == cycle) begin
                        st_d.dir  = DIR_DOWN;
                        st_d.peak = 1'b1;
                    end
                end
            end else begin
                if (st_q.value == '0) begin
                    st_d.dir    = DIR_UP;
                    st_d.valley = 1'b1;
                end else begin
                    st_d.value = dec(st_q.value);
                    if (st_q.value == cnt_t'(1)) begin
                        st_d.dir    = DIR_UP;
                        st_d.valley = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= tbase_reset();
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int PSC_W   = 8,
    parameter int CKSEL_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [PSC_W-1:0]   psc,
    input  logic [CKSEL_W-1:0] cksel,
    input  logic               comp_mode,
    input  logic [CNT_W-1:0]   cycle,
    input  logic               wr_en,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   count,
    output logic               dir_down,
    output logic               peak,
    output logic               valley
);
    logic   tick;
    tbase_t state;

    pwm_prescaler #(
        .PSC_W  (PSC_W),
        .CKSEL_W(CKSEL_W)
    ) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .psc  (psc),
        .cksel(cksel),
        .tick (tick)
    );

    pwm_cnt_core u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .comp_mode(comp_mode),
        .cycle    (cycle),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .state    (state)
    );

    assign count    = state.value;
    assign dir_down = (state.dir == DIR_DOWN);
    assign peak     = state.peak;
    assign valley   = state.valley;

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
    import pwm_timebase_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic run,
    input logic comp_mode,
    input cnt_t cycle,
    input logic wr_en,
    input cnt_t wr_data,
    input logic tick,
    input cnt_t count,
    input logic dir_down,
    input logic peak,
    input logic valley
);
    // R2
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_en) |=> $stable(count));

    // R2
    no_tick_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);

    // R3
    write_loads_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (count == $past(wr_data)));

    // R5
    saw_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (!comp_mode && tick && !wr_en && count == cycle && cycle != '0)
        |=> (count == '0 && peak));

    // R6
    saw_zero_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (!comp_mode && !wr_en && cycle == '0 && count == '0) |=> (count == '0));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(peak && valley));

    // R9
    peak_single_chk: assert property (@(posedge clk) disable iff (rst)
        peak |=> !peak);

    // R9
    valley_single_chk: assert property (@(posedge clk) disable iff (rst)
        valley |=> !valley);

    // R10
    saw_dir_up_chk: assert property (@(posedge clk) disable iff (rst)
        !comp_mode |=> !dir_down);

endmodule

bind pwm_timebase pwm_timebase_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .comp_mode(comp_mode),
    .cycle    (cycle),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .tick     (tick),
    .count    (count),
    .dir_down (dir_down),
    .peak     (peak),
    .valley   (valley)
);

// File: tb/pwm_timebase_bench.sv
`timescale 1ns/1ps
module pwm_timebase_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        run;
    logic [7:0]  psc;
    logic [1:0]  cksel;
    logic        comp_mode;
    logic [15:0] cycle;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] count;
    logic        dir_down, peak, valley;

    always #2 clk = ~clk;

    pwm_timebase u_pwm_timebase (
        .clk(clk), .rst(rst), .run(run), .psc(psc), .cksel(cksel),
        .comp_mode(comp_mode), .cycle(cycle), .wr_en(wr_en), .wr_data(wr_data),
        .count(count), .dir_down(dir_down), .peak(peak), .valley(valley)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string req     = "R1";

    logic [15:0] m_cnt;
    logic        m_dir, m_pk, m_vl;
    int          m_k;

    function automatic int period(int p, int s);
        return (p + 1) * (1 << s);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic turn(logic to_down);
        m_dir = to_down;
        if (to_down) m_pk = 1'b1; else m_vl = 1'b1;
    endtask

    task automatic model_edge();
        logic tk;
        tk   = run && (m_k == period(psc, cksel) - 1);
        m_pk = 1'b0;
        m_vl = 1'b0;
        if (rst) begin
            m_cnt = 16'h0001; m_dir = 1'b0; m_k = 0;
            return;
        end
        m_k = !run ? 0 : (tk ? 0 : m_k + 1);
        if (!comp_mode) m_dir = 1'b0;
        if (wr_en) begin
            m_cnt = wr_data;
        end else if (tk) begin
            if (!comp_mode) begin
                if (m_cnt == cycle) begin
                    m_pk  = (cycle != 0);
                    m_cnt = 0;
                end else m_cnt = m_cnt + 1;
            end else if (!m_dir) begin
                if (m_cnt >= cycle) turn(1'b1);
                else begin
                    m_cnt = m_cnt + 1;
                    if (m_cnt == cycle) turn(1'b1);
                end
            end else begin
                if (m_cnt == 0) turn(1'b0);
                else begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) turn(1'b0);
                end
            end
        end
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        #1;
        chk({req, " count"}, count, m_cnt);
        chk({req, " dir"}, dir_down, m_dir);
        chk({req, " peak"}, peak, m_pk);
        chk({req, " valley"}, valley, m_vl);
        chk("R9 strobes", {peak && valley}, 1'b0);
    endtask

    task automatic load(logic [15:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        rst = 1'b1; run = 1'b0; psc = 0; cksel = 0; comp_mode = 1'b0;
        cycle = 0; wr_en = 1'b0; wr_data = 0;
        step(); step();
        rst = 1'b0;
        req = "R1";
        step();
        chk("R1 reset count", count, 16'h0001);
        chk("R1 reset dir", dir_down, 1'b0);
        chk("R1 reset strobes", {peak, valley}, 2'b00);

        req = "R2";
        cycle = 16'd9;
        repeat (5) step();
        chk("R2 hold", count, 16'h0001);

        req = "R3";
        load(16'h1234);
        chk("R3 load", count, 16'h1234);

        req = "R4";
        load(16'd0);
        psc = 8'd2; cksel = 2'd1; cycle = 16'd100; run = 1'b1;
        repeat (5) step();
        chk("R4 before first tick", count, 16'd0);
        repeat (7) step();
        chk("R4 two ticks in 12 cycles", count, 16'd2);
        run = 1'b0; step();

        req = "R5";
        psc = 0; cksel = 0; cycle = 16'd4;
        load(16'd3);
        run = 1'b1;
        step();
        chk("R5 reach cycle", count, 16'd4);
        step();
        chk("R5 restart", count, 16'd0);
        chk("R5 restart peak", peak, 1'b1);
        run = 1'b0; step();

        req = "R6";
        cycle = 0;
        load(16'd0);
        run = 1'b1;
        repeat (10) step();
        chk("R6 zero cycle", count, 16'd0);
        run = 1'b0; step();

        req = "R7";
        comp_mode = 1'b1; cycle = 16'd3;
        load(16'd0);
        run = 1'b1;
        step(); chk("R7 up1", count, 16'd1);
        step(); chk("R7 up2", count, 16'd2);
        step(); chk("R7 top", count, 16'd3);
        chk("R7 dir turns down", dir_down, 1'b1);
        chk("R7 peak", peak, 1'b1);
        req = "R8";
        step(); chk("R8 down2", count, 16'd2);
        chk("R8 peak one cycle", peak, 1'b0);
        step(); chk("R8 down1", count, 16'd1);
        step(); chk("R8 bottom", count, 16'd0);
        chk("R8 dir turns up", dir_down, 1'b0);
        chk("R8 valley", valley, 1'b1);
        step(); chk("R8 climbs again", count, 16'd1);

        req = "R7";
        run = 1'b0;
        load(16'd8);
        run = 1'b1;
        step();
        chk("R7 above cycle holds", count, 16'd8);
        chk("R7 above cycle turns", dir_down, 1'b1);
        step();
        chk("R7 then descends", count, 16'd7);

        req = "R10";
        run = 1'b0; comp_mode = 1'b0;
        step();
        chk("R10 dir cleared", dir_down, 1'b0);

        for (int seg = 0; seg < 40; seg++) begin
            run = 1'b0;
            psc = 8'($urandom % 3);
            cksel = 2'($urandom % 4);
            comp_mode = 1'($urandom % 2);
            cycle = 16'($urandom % 24);
            if (seg < 4) cycle = 16'(seg % 2);
            req = comp_mode ? "R7/R8" : "R5";
            load(16'($urandom % 32));
            for (int i = 0; i < 200; i++) begin
                run     = ($urandom % 16) != 0;
                wr_en   = ($urandom % 64) == 0;
                wr_data = 16'($urandom % 32);
                step();
            end
            wr_en = 1'b0;
        end

        summary();
        $finish;
    end

endmodule